// File: doc/BRIEF.md
# DMA Channel Run Control

This block holds the run state of one DMA channel: an active flag that software sets and clears, and a transfer counter. The bus engine reports each finished transfer on `xfer_end` and each finished block on `blk_end`. It holds `bus_busy` high while a transfer is under way. The block counts the transfers or blocks and drops the active flag when the count runs out. It also drops the flag on a repeat-area overflow, on NMI, on standby and on reset. In each hardware stop case it raises a one-cycle `done` pulse with a cause code.

A software clear does not stop the channel at once. The request is held as a pending halt and takes effect only at a safe point. In normal mode that point is the end of the current transfer. In block mode it is the end of the current block. In burst mode it comes after at most three further transfers. The active flag reads 1 until the halt takes effect. While the channel runs, writes to the count and mode are dropped.

Top module: `dma_run_ctl`

## Requirements
- R1: Reset gives active=0, count=0, mode=0 and done=0. While `standby` is high, active and any pending halt are cleared with no done pulse, and standby wins over a same-cycle software set.
- R2: With the channel idle, `act_wr` with `act_wdata`=1 sets active on the next edge. Count and mode written in the same cycle are also taken.
- R3: In normal mode (mode 0) and burst mode (mode 2), each `xfer_end` while active decrements the whole 24-bit count. The transfer that takes the count from 1 to 0 clears active and gives done with cause 0.
- R4: In block mode (mode 1), bits 15:0 decrement by one per `blk_end` and bits 23:16 hold their value. `xfer_end` leaves the count unchanged. The block that takes bits 15:0 from 1 to 0 clears active with cause 0.
- R5: `ovf_req` together with the transfer-end strobe of the mode (`xfer_end` in modes 0 and 2, `blk_end` in mode 1) clears active with cause 1. `ovf_req` alone has no effect.
- R6: `nmi` while active clears active on the next edge with cause 2.
- R7: In mode 0, a 0-write to active makes a halt pending while active stays 1. The halt takes effect, with cause 3, at the next `xfer_end` or on any later cycle that has `bus_busy` low.
- R8: In mode 1, a pending halt keeps active at 1 through any number of `xfer_end` strobes and idle cycles, and takes effect at the next `blk_end` with cause 3.
- R9: In mode 2, after the cycle that carries the 0-write, at most three more `xfer_end` strobes are accepted. The halt takes effect at the third of them, or earlier on a cycle with `bus_busy` low, with cause 3.
- R10: While active, writes to count and mode are ignored.
- R11: `done` is high for exactly one cycle, and only in the cycle right after a hardware clear of active.
- R12: When stop events coincide, the cause follows the priority NMI (2) > count end (0) > overflow (1) > software halt (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Hardware standby level; clears run state |
| nmi | input | 1 | NMI strobe |
| act_wr | input | 1 | Software write strobe for the active flag |
| act_wdata | input | 1 | Value written to the active flag |
| cnt_wr | input | 1 | Software write strobe for the counter |
| cnt_wdata | input | 24 | Counter write value |
| mode_wr | input | 1 | Software write strobe for the mode |
| mode_wdata | input | 2 | Mode write value (0 normal, 1 block, 2 burst) |
| bus_busy | input | 1 | A transfer is in progress on the bus |
| xfer_end | input | 1 | One transfer has finished |
| blk_end | input | 1 | One block has finished |
| ovf_req | input | 1 | Repeat-area overflow request at a transfer end |
| active | output | 1 | Channel active flag |
| count | output | 24 | Transfer counter |
| mode | output | 2 | Current mode |
| done | output | 1 | One-cycle pulse on a hardware clear of active |
| done_cause | output | 2 | Stop cause: 0 count, 1 overflow, 2 NMI, 3 software |

## Verification
A stale pending-halt flag shows up on the `active` port as an early stop on the first idle cycle or strobe after a restart. A tail counter that is off by one ends a burst halt one transfer too early or too late. The bench sweeps every stop point from zero to three transfers, so either fault appears within four strobes. Counter faults show on `count` after the first strobe. A wrong `done_cause` shows in the same cycle as the pulse, because the bench makes the stop events coincide.

// File: rtl/dma_run_ctl.sv
module dma_run_ctl #(
  parameter int CNT_W = 24,
  parameter int BLK_W = 16,
  parameter int TAIL  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             nmi,
  input  logic             act_wr,
  input  logic             act_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             bus_busy,
  input  logic             xfer_end,
  input  logic             blk_end,
  input  logic             ovf_req,
  output logic             active,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       mode,
  output logic             done,
  output logic [1:0]       done_cause
);
  localparam int TAIL_W = $clog2(TAIL + 1);
  localparam logic [1:0] M_BLK = 2'd1, M_BURST = 2'd2;
  localparam logic [1:0] C_CNT = 2'd0, C_OVF = 2'd1, C_NMI = 2'd2, C_SW = 2'd3;

  logic              pend;
  logic [TAIL_W-1:0] tail;

  wire             is_blk   = (mode == M_BLK);
  wire             is_burst = (mode == M_BURST);
  wire             bound    = is_blk ? blk_end : xfer_end;
  wire [BLK_W-1:0] blk_cnt  = count[BLK_W-1:0];
  wire             last     = is_blk ? (blk_cnt == BLK_W'(1)) : (count == CNT_W'(1));
  wire             cnt_stop = bound & last;
  wire             ovf_stop = bound & ovf_req;
  wire             sw_point = is_blk   ? blk_end :
                              is_burst ? ((xfer_end && tail == TAIL_W'(1)) || !bus_busy) :
                                         (xfer_end || !bus_busy);
  wire             sw_stop  = pend & sw_point;
  wire             hw_stop  = active & (nmi | cnt_stop | ovf_stop | sw_stop);
  wire [1:0]       cause    = nmi ? C_NMI : cnt_stop ? C_CNT : ovf_stop ? C_OVF : C_SW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      mode  <= '0;
    end else if (!active) begin
      if (cnt_wr)  count <= cnt_wdata;
      if (mode_wr) mode  <= mode_wdata;
    end else if (bound) begin
      if (is_blk) count[BLK_W-1:0] <= blk_cnt - BLK_W'(1);
      else        count            <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; pend <= 1'b0; tail <= '0; done <= 1'b0; done_cause <= '0;
    end else if (standby) begin
      active <= 1'b0; pend <= 1'b0; tail <= '0; done <= 1'b0;
    end else begin
      done <= hw_stop;
      if (hw_stop) begin
        active     <= 1'b0;
        pend       <= 1'b0;
        tail       <= '0;
        done_cause <= cause;
      end else if (!active) begin
        if (act_wr && act_wdata) active <= 1'b1;
      end else if (act_wr && !act_wdata && !pend) begin
        pend <= 1'b1;
        tail <= TAIL_W'(TAIL);
      end else if (pend && is_burst && xfer_end) begin
        tail <= tail - TAIL_W'(1);
      end
    end
  end

  AST_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !active && !done); // R1
  AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active && $past(active)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(mode)); // R10
  AST_BLK_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_blk && $past(active)) |-> $stable(count[CNT_W-1:BLK_W])); // R4
  AST_BLK_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_blk && !blk_end && !nmi && !standby) |=> active); // R8
endmodule

// File: tb/dma_run_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_run_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic standby = 0, nmi = 0, act_wr = 0, act_wdata = 0, cnt_wr = 0, mode_wr = 0;
  logic [23:0] cnt_wdata = '0;
  logic [1:0] mode_wdata = '0;
  logic bus_busy = 0, xfer_end = 0, blk_end = 0, ovf_req = 0;
  logic active, done;
  logic [23:0] count;
  logic [1:0] mode, done_cause;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_run_ctl dut_i (.clk(clk), .rst_n(rst_n), .standby(standby), .nmi(nmi),
    .act_wr(act_wr), .act_wdata(act_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .bus_busy(bus_busy),
    .xfer_end(xfer_end), .blk_end(blk_end), .ovf_req(ovf_req), .active(active),
    .count(count), .mode(mode), .done(done), .done_cause(done_cause));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    act_wr = 0; cnt_wr = 0; mode_wr = 0; xfer_end = 0; blk_end = 0; ovf_req = 0; nmi = 0;
  endtask

  task automatic start(input logic [1:0] m, input logic [23:0] c);
    mode_wr = 1; mode_wdata = m; cnt_wr = 1; cnt_wdata = c; act_wr = 1; act_wdata = 1;
    tick();
    chk("R2 active set", active, 1); chk("R2 count load", count, c); chk("R2 mode load", mode, m);
  endtask

  task automatic halt();
    act_wr = 1; act_wdata = 0;
  endtask

  task automatic stopped(input string r, input logic [1:0] c);
    chk({r, " active"}, active, 0); chk({r, " done"}, done, 1); chk({r, " cause"}, done_cause, c);
    tick(); chk("R11 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset active", active, 0); chk("R1 reset count", count, 0);
    chk("R1 reset mode", mode, 0); chk("R1 reset done", done, 0);
    rst_n = 1; @(negedge clk);

    // R3 count sweep, normal and burst
    for (int m = 0; m <= 2; m += 2)
      for (int n = 1; n <= 5; n++) begin
        start(2'(m), 24'(n)); bus_busy = 1;
        for (int i = 1; i <= n; i++) begin
          xfer_end = 1; tick();
          chk("R3 count", count, 24'(n - i));
          if (i < n) begin chk("R3 still active", active, 1); chk("R11 no done", done, 0); end
        end
        stopped("R3 end", 2'd0);
      end

    // R10 writes ignored while active, R6 NMI
    start(2'd0, 24'hFFFFFF); bus_busy = 1;
    xfer_end = 1; tick(); chk("R3 full width", count, 24'hFFFFFE);
    cnt_wr = 1; cnt_wdata = 24'h5; mode_wr = 1; mode_wdata = 2'd1; tick();
    chk("R10 count kept", count, 24'hFFFFFE); chk("R10 mode kept", mode, 0); chk("R10 active", active, 1);
    nmi = 1; tick(); stopped("R6 nmi", 2'd2);

    // R4 block sweep
    for (int k = 1; k <= 4; k++) begin
      start(2'd1, {8'hA5, 16'(k)});
      xfer_end = 1; tick(); chk("R4 xfer ignored", count, {8'hA5, 16'(k)});
      for (int b = 1; b <= k; b++) begin
        blk_end = 1; tick();
        chk("R4 block count", count, {8'hA5, 16'(k - b)});
        if (b < k) chk("R4 still active", active, 1);
      end
      stopped("R4 end", 2'd0);
    end

    // R5 overflow
    start(2'd0, 24'd10); ovf_req = 1; tick();
    chk("R5 ovf alone active", active, 1); chk("R5 ovf alone count", count, 10);
    ovf_req = 1; xfer_end = 1; tick(); chk("R5 count", count, 9); stopped("R5 ovf", 2'd1);
    start(2'd1, {8'h03, 16'd5}); ovf_req = 1; xfer_end = 1; tick();
    chk("R5 block ovf needs blk_end", active, 1);
    ovf_req = 1; blk_end = 1; tick(); stopped("R5 block ovf", 2'd1);

    // R12 priority
    start(2'd0, 24'd1); nmi = 1; xfer_end = 1; tick(); stopped("R12 nmi over count", 2'd2);
    start(2'd0, 24'd1); ovf_req = 1; xfer_end = 1; tick(); stopped("R12 count over ovf", 2'd0);
    start(2'd0, 24'd5); bus_busy = 1; halt(); tick();
    ovf_req = 1; xfer_end = 1; tick(); stopped("R12 ovf over sw", 2'd1);

    // R7 normal-mode halt
    start(2'd0, 24'd20); bus_busy = 1; halt(); tick();
    for (int i = 0; i < 3; i++) begin tick(); chk("R7 held while busy", active, 1); end
    xfer_end = 1; tick(); chk("R7 count", count, 19); stopped("R7 sw at xfer end", 2'd3);
    start(2'd0, 24'd20); bus_busy = 1; halt(); tick(); chk("R7 reads 1", active, 1);
    bus_busy = 0; tick(); stopped("R7 sw when idle", 2'd3);

    // R8 block-mode halt
    for (int x = 0; x <= 3; x++) begin
      start(2'd1, {8'h10, 16'd9}); bus_busy = 0; halt(); tick();
      for (int i = 0; i < x; i++) begin
        xfer_end = 1; tick(); chk("R8 held on xfer", active, 1);
        tick(); chk("R8 held idle", active, 1);
      end
      blk_end = 1; tick(); chk("R8 count", count, {8'h10, 16'd8}); stopped("R8 sw at block", 2'd3);
    end

    // R9 burst-mode halt
    for (int j = 0; j <= 3; j++) begin
      start(2'd2, 24'd100); bus_busy = 1; halt(); xfer_end = 1; tick();
      chk("R9 write cycle", active, 1); chk("R9 count", count, 99);
      for (int t = 1; t <= j; t++) begin
        xfer_end = 1; tick();
        if (t < 3) chk("R9 tail active", active, 1);
      end
      if (j < 3) begin bus_busy = 0; tick(); end
      chk("R9 final count", count, 24'(99 - j));
      stopped("R9 burst stop", 2'd3);
    end

    // R1 standby
    start(2'd1, {8'h01, 16'd3}); halt(); tick();
    standby = 1; tick(); chk("R1 standby active", active, 0); chk("R1 standby done", done, 0);
    act_wr = 1; act_wdata = 1; tick(); chk("R1 standby beats set", active, 0);
    standby = 0; act_wr = 1; act_wdata = 1; tick(); chk("R1 restart", active, 1);
    blk_end = 1; tick(); chk("R1 pend cleared", active, 1); chk("R1 count", count, {8'h01, 16'd2});
    nmi = 1; tick(); stopped("R6 nmi block", 2'd2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule